// File: doc/BRIEF.md
# Bit-Matrix Corner-Turn Buffer

This block collects a frame of 32 data words, each 32 bits wide, and returns them as 32 bit planes. Plane `i` is made of bit `i` from every stored word, so the frame comes out as a single-bit matrix flipped across its diagonal. Words enter one per accepted write, and planes leave one per accepted read.

Each side uses a valid/ready handshake. Each side also shows the index of the next word or plane it will take or give. A status flag reports that a complete frame is held and can be read. The block loads a whole frame, then unloads the whole frame, and only then accepts the next frame. A synchronous reset drops any frame in progress.

Top module: `corner_turn_buffer`

## Requirements
- R1: While `rst` is high and in the cycle after it, `wr_ready` is 1, `rd_valid` and `frame_full` are 0, and `wr_index` and `rd_index` are 0.
- R2: A write is accepted on a clock edge where `wr_valid` and `wr_ready` are both 1. It stores `wr_data` as word number `wr_index`, and `wr_index` then steps by one, from 0 up to 31.
- R3: `frame_full` goes to 1 in the cycle after the write at `wr_index` 31 is accepted, and `wr_index` returns to 0.
- R4: `wr_ready` is 0 from the cycle after the 32nd accepted write up to and including the cycle in which the 32nd plane is read.
- R5: `rd_valid` is 1 exactly while `frame_full` is 1. A high `rd_ready` has no effect while `rd_valid` is 0.
- R6: Planes leave in ascending order, starting with plane 0. `rd_index` steps by one on each edge where `rd_valid` and `rd_ready` are both 1.
- R7: While `rd_valid` is 1, bit `k` of `rd_data` equals bit `rd_index` of stored word `k`. Plane 0 therefore carries the LSBs of all words, and plane 31 carries the MSBs.
- R8: `frame_full` returns to 0 in the cycle after plane 31 is read. `rd_index` returns to 0, and `wr_ready` is 1 again in that cycle.
- R9: Writes offered while `wr_ready` is 0 are ignored: every plane of the held frame reads back unchanged.
- R10: A reset in the middle of loading discards the partial frame. The next frame starts at `wr_index` 0, and its planes carry only the new words.
- R11: When `rst` is high in the same cycle as an offered write or read handshake, the reset wins: the handshake is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Input word offered |
| wr_ready | output | 1 | Block can take a word (loading phase) |
| wr_index | output | 5 | Position the next accepted word will fill |
| wr_data | input | 32 | Input word |
| rd_valid | output | 1 | A plane is available |
| rd_ready | input | 1 | Consumer takes the current plane |
| rd_index | output | 5 | Number of the plane now on `rd_data` |
| rd_data | output | 32 | Current bit plane |
| frame_full | output | 1 | A complete frame is held |

## Verification
Two events can land on the same clock edge. The first is a synchronous reset together with an accepted handshake on either side. The second is the last read of a frame together with a write that is being offered. The bench drives reset while `wr_valid` is high in the middle of loading, and while `rd_ready` is high in the middle of unloading. It also holds `wr_valid` high through the whole unload, so that the edge of the 32nd read carries a pending write. A reference model compares every output on every cycle. It requires that the reset clears both counters and the flag, and that a write is taken only in the cycle after `frame_full` drops.

// File: rtl/ctb_pkg.sv
package ctb_pkg;

    typedef enum logic {
        PH_LOAD   = 1'b0,
        PH_UNLOAD = 1'b1
    } ctb_phase_e;

endpackage

// File: rtl/ctb_wrap_cnt.sv
module ctb_wrap_cnt #(
    parameter int LIMIT = 32,
    parameter int CW    = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          at_last
);

    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    assign at_last = (cnt_q == LAST);
    assign cnt     = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc) begin
            cnt_d = at_last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // R2 / R6: step by one per accepted transfer, wrap after the last position
    a_r2_r6_cnt_step: assert property (@(posedge clk) disable iff (rst)
        (inc && !at_last) |=> (cnt_q == $past(cnt_q) + 1'b1));
    a_r3_r8_cnt_wrap: assert property (@(posedge clk) disable iff (rst)
        (inc && at_last) |=> (cnt_q == '0));
    a_r9_cnt_hold: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(cnt_q));

endmodule

// File: rtl/ctb_ctrl.sv
module ctb_ctrl
    import ctb_pkg::*;
#(
    parameter int NUM_WORDS  = 32,
    parameter int NUM_PLANES = 32,
    parameter int WI = (NUM_WORDS  > 1) ? $clog2(NUM_WORDS)  : 1,
    parameter int RI = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic          rd_ready,
    output logic          wr_ready,
    output logic          rd_valid,
    output logic          frame_full,
    output logic          wr_fire,
    output logic [WI-1:0] wr_idx,
    output logic [RI-1:0] rd_idx
);

    typedef struct packed {
        ctb_phase_e phase;
        logic       full;
    } ctrl_state_t;

    ctrl_state_t st_d;
    ctrl_state_t st_q;

    logic rd_fire;
    logic wr_last;
    logic rd_last;

    assign wr_ready   = (st_q.phase == PH_LOAD);
    assign rd_valid   = (st_q.phase == PH_UNLOAD);
    assign frame_full = st_q.full;
    assign wr_fire    = wr_valid && wr_ready;
    assign rd_fire    = rd_ready && rd_valid;

    ctb_wrap_cnt #(.LIMIT(NUM_WORDS), .CW(WI)) u_wr_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (wr_fire),
        .cnt     (wr_idx),
        .at_last (wr_last)
    );

    ctb_wrap_cnt #(.LIMIT(NUM_PLANES), .CW(RI)) u_rd_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (rd_fire),
        .cnt     (rd_idx),
        .at_last (rd_last)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_LOAD: begin
                if (wr_fire && wr_last) begin
                    st_d.phase = PH_UNLOAD;
                    st_d.full  = 1'b1;
                end
            end
            PH_UNLOAD: begin
                if (rd_fire && rd_last) begin
                    st_d.phase = PH_LOAD;
                    st_d.full  = 1'b0;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_LOAD;
            st_q.full  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: flag set in the cycle after the last word is taken
    a_r3_full_after_last_wr: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && wr_last) |=> (frame_full && wr_idx == '0));
    // R8: flag cleared in the cycle after the last plane is taken
    a_r8_empty_after_last_rd: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && rd_last) |=> (!frame_full && wr_ready && rd_idx == '0));
    // R4: no write accepted while a full frame is held
    a_r4_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
        frame_full |-> !wr_fire);
    // R5: the read counter stays parked while loading
    a_r5_rd_idle_in_load: assert property (@(posedge clk) disable iff (rst)
        !frame_full |-> (rd_idx == '0));

endmodule

// File: rtl/ctb_bit_array.sv
module ctb_bit_array #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 32,
    parameter int WI = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    parameter int RI = (WORD_W    > 1) ? $clog2(WORD_W)    : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [WI-1:0]        wr_row,
    input  logic [WORD_W-1:0]    wr_word,
    input  logic [RI-1:0]        rd_plane,
    output logic [NUM_WORDS-1:0] plane_bits
);

    logic [NUM_WORDS-1:0][WORD_W-1:0] mem_d;
    logic [NUM_WORDS-1:0][WORD_W-1:0] mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_row] = wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mem_q <= '0;
        else     mem_q <= mem_d;
    end

    // Each output bit k taps row k at the selected column
    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_gather
        assign plane_bits[k] = mem_q[k][rd_plane];
    end

    // R9: rows only change on an accepted write
    a_r9_rows_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mem_q));
    // R2: the addressed row captures the offered word
    a_r2_row_capture: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem_q[$past(wr_row)] == $past(wr_word)));

endmodule

// File: rtl/corner_turn_buffer.sv
module corner_turn_buffer #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 32,
    parameter int WI = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    parameter int RI = (WORD_W    > 1) ? $clog2(WORD_W)    : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_valid,
    output logic                 wr_ready,
    output logic [WI-1:0]        wr_index,
    input  logic [WORD_W-1:0]    wr_data,
    output logic                 rd_valid,
    input  logic                 rd_ready,
    output logic [RI-1:0]        rd_index,
    output logic [NUM_WORDS-1:0] rd_data,
    output logic                 frame_full
);

    logic wr_fire;

    ctb_ctrl #(
        .NUM_WORDS  (NUM_WORDS),
        .NUM_PLANES (WORD_W),
        .WI         (WI),
        .RI         (RI)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_valid   (wr_valid),
        .rd_ready   (rd_ready),
        .wr_ready   (wr_ready),
        .rd_valid   (rd_valid),
        .frame_full (frame_full),
        .wr_fire    (wr_fire),
        .wr_idx     (wr_index),
        .rd_idx     (rd_index)
    );

    ctb_bit_array #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .WI        (WI),
        .RI        (RI)
    ) u_array (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_fire),
        .wr_row     (wr_index),
        .wr_word    (wr_data),
        .rd_plane   (rd_index),
        .plane_bits (rd_data)
    );

    // R5: reads are offered only with a complete frame held
    a_r5_valid_means_full: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> frame_full);
    // R6: a stalled read keeps its plane and index
    a_r6_stall_holds_plane: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> ($stable(rd_index) && $stable(rd_data)));

endmodule

// File: tb/corner_turn_buffer_tb.sv
module corner_turn_buffer_tb;

    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          rd_ready = 1'b0;
    logic          wr_ready;
    logic [4:0]    wr_index;
    logic          rd_valid;
    logic [4:0]    rd_index;
    logic [31:0]   rd_data;
    logic          frame_full;

    always #2 clk = ~clk;

    corner_turn_buffer u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .wr_index   (wr_index),
        .wr_data    (wr_data),
        .rd_valid   (rd_valid),
        .rd_ready   (rd_ready),
        .rd_index   (rd_index),
        .rd_data    (rd_data),
        .frame_full (frame_full)
    );

    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;
    logic        done   = 1'b0;
    string       data_tag = "R7";

    // Behavioural reference
    logic [31:0] m_words [N];
    int          m_wr   = 0;
    int          m_rd   = 0;
    bit          m_full = 0;
    logic [31:0] seed   = 32'h1234_5678;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d",
                     tag, what, act, exp, cycles);
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_wr = 0; m_rd = 0; m_full = 0;
            for (int k = 0; k < N; k++) m_words[k] = '0;
        end else if (!m_full) begin
            if (wr_valid) begin
                m_words[m_wr] = wr_data;
                if (m_wr == N - 1) begin m_wr = 0; m_full = 1; end
                else m_wr++;
            end
        end else if (rd_ready) begin
            if (m_rd == N - 1) begin m_rd = 0; m_full = 0; end
            else m_rd++;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            logic [31:0] exp_plane;
            check("R4", "wr_ready",   32'(wr_ready),   32'(!m_full));
            check("R3", "frame_full", 32'(frame_full), 32'(m_full));
            check("R5", "rd_valid",   32'(rd_valid),   32'(m_full));
            check("R2", "wr_index",   32'(wr_index),   32'(m_wr));
            check("R6", "rd_index",   32'(rd_index),   32'(m_rd));
            if (m_full) begin
                exp_plane = '0;
                for (int k = 0; k < N; k++) exp_plane[k] = m_words[k][m_rd];
                check(data_tag, "rd_data", rd_data, exp_plane);
            end
        end
    end

    task automatic drive(input logic v, input logic [31:0] d, input logic r);
        @(posedge clk);
        #1;
        wr_valid = v;
        wr_data  = d;
        rd_ready = r;
    endtask

    // Load a frame; pattern 0 = one-hot rows, 1 = random with gaps
    task automatic load_frame(input int pat);
        int t = 0;
        while (!frame_full) begin
            logic [31:0] d;
            bit v;
            if (pat == 0) begin
                d = 32'h1 << wr_index;
                v = 1'b1;
            end else begin
                seed = next_rand(seed);
                d = seed;
                v = (t % 3) != 1;
            end
            drive(v, d, 1'b1);
            t++;
        end
    endtask

    // Unload a frame; junk writes stay offered (R9)
    task automatic unload_frame(input bit gaps);
        int t = 0;
        while (frame_full) begin
            drive(1'b1, 32'hDEAD_BEEF ^ 32'(t), gaps ? ((t % 4) != 2) : 1'b1);
            t++;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "wr_ready",   32'(wr_ready),   32'd1);
        check("R1", "rd_valid",   32'(rd_valid),   32'd0);
        check("R1", "frame_full", 32'(frame_full), 32'd0);
        check("R1", "wr_index",   32'(wr_index),   32'd0);
        check("R1", "rd_index",   32'(rd_index),   32'd0);
        rst = 1'b0;

        // R5: reading an empty buffer has no effect
        repeat (3) drive(1'b0, '0, 1'b1);

        // R7: one-hot rows give one-hot planes; R9 junk writes during unload
        data_tag = "R7";
        load_frame(0);
        data_tag = "R9";
        unload_frame(1'b0);

        // R7/R8: random words, gaps on both sides
        data_tag = "R7";
        load_frame(1);
        data_tag = "R8";
        unload_frame(1'b1);

        // R10: partial frame then reset
        for (int i = 0; i < 10; i++) drive(1'b1, 32'hA5A5_0000 | 32'(i), 1'b0);
        @(posedge clk); #1; rst = 1'b1; wr_valid = 1'b1; // R11: write offered with reset
        @(posedge clk); #1; rst = 1'b0;
        data_tag = "R10";
        load_frame(1);
        unload_frame(1'b0);

        // R11: reset together with an accepted read mid-unload
        load_frame(1);
        for (int i = 0; i < 7; i++) drive(1'b0, '0, 1'b1);
        @(posedge clk); #1; rst = 1'b1; rd_ready = 1'b1;
        @(posedge clk); #1; rst = 1'b0; rd_ready = 1'b0;
        data_tag = "R11";
        load_frame(0);
        unload_frame(1'b1);

        repeat (3) drive(1'b0, '0, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule